// File: doc/BRIEF.md
# Clock Output Gating and Power-Up Strap Controller

This block sits between the frequency synthesis of a multi-output system clock generator and its output pins. It receives CPU, PCI, 48 MHz and reference clocks that are already generated. It stops whole output groups cleanly in the low state under three active-low control inputs: a power-down, a CPU-clock stop and a PCI-clock stop. It also drives an output enable for every clock pin.

Three pins serve two purposes. For a fixed number of reference-clock cycles after reset they are read as configuration straps:
- a spread-spectrum select;
- a 48/24 MHz select for a shared output;
- a global tri-state select.

Once sampling is done, the spread-spectrum and frequency-select pins carry the reference clock. The shared pin carries 48 MHz, or 48 MHz divided by two. A tri-state strap read low keeps every output disabled until the next reset. Each enable change is synchronized into the clock domain it affects and takes effect only while that clock is low. No shortened pulse can appear.

Top module: `clk_out_ctrl`

## Requirements
- R1: After reset release, every output enable and `ss_en` stay 0 for the first STRAP_WIN reference-clock cycles (the strap window).
- R2: At the end of the window, `ss_en` is set to the inverse of `strap_ss_in`: 0 enables spread spectrum. The value then holds until the next reset.
- R3: With `strap_sel_in` sampled 0, `dual_out` runs at the `f48_clk` rate. With it sampled 1, `dual_out` runs at half that rate.
- R4: With `strap_ts_in` sampled 0, every output enable stays 0 until the next reset, whatever the control inputs do. With it sampled 1, every output enable is 1 after the window.
- R5: While `cs_n` is low, all `cpu_out` bits are stopped and held low. While `cs_n` is high and `pd_n` is high, they follow `cpu_clk`.
- R6: While `ps_n` is low, all `pci_out` bits are stopped low, and `pci_f_out` keeps following `pci_clk`.
- R7: While `pd_n` is low, every clock output is stopped low: `cpu_out`, `pci_out`, `pci_f_out`, `fix48_out`, `dual_out` and `ref_out`.
- R8: `fix48_out` follows `f48_clk` regardless of `cs_n` and `ps_n`.
- R9: After the window, both `ref_out` bits (the former strap pins) follow `ref_clk`.
- R10: When `pd_n` returns high, the outputs resume and the sampled strap values are unchanged.
- R11: Every high pulse on a gated output has the full high-phase width of its source clock. A gate opens or closes only while its source clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also times the strap window |
| cpu_clk | input | 1 | Source CPU clock |
| pci_clk | input | 1 | Source PCI clock |
| f48_clk | input | 1 | Source 48 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| pd_n | input | 1 | Power-down, active low |
| cs_n | input | 1 | CPU clock stop, active low |
| ps_n | input | 1 | PCI clock stop, active low |
| strap_ss_in | input | 1 | Pin value read on the spread-spectrum strap pin |
| strap_sel_in | input | 1 | Pin value read on the 48/24 select strap pin |
| strap_ts_in | input | 1 | Pin value read on the tri-state strap pin |
| cpu_out | output | NCPU | Gated CPU clocks |
| cpu_oe | output | NCPU | CPU pin enables |
| pci_f_out | output | 1 | Free-running PCI clock (stopped only by power-down) |
| pci_f_oe | output | 1 | Enable for the free-running PCI pin |
| pci_out | output | NPCI | Stoppable PCI clocks |
| pci_oe | output | NPCI | PCI pin enables |
| fix48_out | output | 1 | Fixed 48 MHz clock |
| fix48_oe | output | 1 | Enable for the fixed 48 MHz pin |
| dual_out | output | 1 | 48 or 24 MHz clock on the shared strap pin |
| dual_oe | output | 1 | Enable for the shared strap pin |
| ref_out | output | 2 | Reference clocks on the two former strap pins |
| ref_oe | output | 2 | Enables for the two former strap pins |
| ss_en | output | 1 | Spread-spectrum enable flag |

## Verification
The bench builds the block with STRAP_WIN=4, NCPU=2 and NPCI=3. The short window keeps each reset short enough that the bench can sweep all eight strap combinations. For every combination with outputs enabled, it also sweeps all eight combinations of `pd_n`, `cs_n` and `ps_n`. The bench counts edges on each output against edges on its source clock over a fixed interval, which covers both the half-rate shared pin and the stopped-low cases. Throughout the run, pulse-width monitors on the CPU and PCI outputs catch any shortened pulse caused by a stop control changing at an arbitrary phase.

// File: rtl/clkc_pkg.sv
`timescale 1ns/100ps
// Shared types for the clock output controller.
package clkc_pkg;

    // Strap values as read from the pins (active-low meanings kept raw).
    typedef struct packed {
        logic ss_n;     // 0 = spread spectrum on
        logic sel48_n;  // 0 = shared pin runs 48 MHz, 1 = 24 MHz
        logic ts_n;     // 0 = all outputs tri-stated
    } strap_t;

    localparam strap_t STRAP_RESET = '{ss_n: 1'b1, sel48_n: 1'b1, ts_n: 1'b1};

endpackage

// File: rtl/strap_sampler.sv
`timescale 1ns/100ps
// Strap sampler: counts WIN reference-clock cycles after reset release,
// then captures the three strap pins once and raises done for good.
// Assumes WIN >= 2 and that the strap pins are stable during the window.
module strap_sampler
    import clkc_pkg::*;
#(
    parameter int WIN = 64
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ss_pin,
    input  logic   sel_pin,
    input  logic   ts_pin,
    output logic   done,
    output strap_t straps
);
    localparam int CW = $clog2(WIN);
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt;

    // Window counter, one-time capture and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            done   <= 1'b0;
            straps <= STRAP_RESET;
        end else if (!done) begin
            if (cnt == LAST) begin
                done   <= 1'b1;
                straps <= '{ss_n: ss_pin, sel48_n: sel_pin, ts_n: ts_pin};
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clk_gate.sv
`timescale 1ns/100ps
// Glitch-free clock gate: run is synchronized into the clk domain by
// SYNC rising-edge stages, then transferred on the falling edge, so the
// enable only changes while clk is low. Assumes SYNC >= 2.
module clk_gate #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic gclk
);
    logic [SYNC-1:0] sync_q;
    logic            en_q;

    // Synchronizer chain for the asynchronous run request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= run;
            for (int i = 1; i < SYNC; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Enable update in the low phase of clk only.
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= sync_q[SYNC-1];
    end

    assign gclk = clk & en_q;
endmodule

// File: rtl/clk_div2.sv
`timescale 1ns/100ps
// Divide-by-two: toggles on every rising edge of clk; output low in reset.
module clk_div2 (
    input  logic clk,
    input  logic rst_n,
    output logic q
);
    // Toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ~q;
    end
endmodule

// File: rtl/clk_out_ctrl.sv
`timescale 1ns/100ps
// Clock output controller: samples the power-up straps, then gates each
// clock group by the active-low stop and power-down controls and drives
// the per-pin enables. Assumes the source clocks run during reset so the
// synchronous resets take effect.
module clk_out_ctrl
    import clkc_pkg::*;
#(
    parameter int NCPU      = 2,
    parameter int NPCI      = 5,
    parameter int STRAP_WIN = 64,
    parameter int SYNC      = 2
) (
    input  logic            ref_clk,
    input  logic            cpu_clk,
    input  logic            pci_clk,
    input  logic            f48_clk,
    input  logic            rst_n,
    input  logic            pd_n,
    input  logic            cs_n,
    input  logic            ps_n,
    input  logic            strap_ss_in,
    input  logic            strap_sel_in,
    input  logic            strap_ts_in,
    output logic [NCPU-1:0] cpu_out,
    output logic [NCPU-1:0] cpu_oe,
    output logic            pci_f_out,
    output logic            pci_f_oe,
    output logic [NPCI-1:0] pci_out,
    output logic [NPCI-1:0] pci_oe,
    output logic            fix48_out,
    output logic            fix48_oe,
    output logic            dual_out,
    output logic            dual_oe,
    output logic [1:0]      ref_out,
    output logic [1:0]      ref_oe,
    output logic            ss_en
);
    localparam int NREF = 2;

    logic   done;
    strap_t straps;
    logic   pins_on;
    logic   cpu_g, pci_g, pcif_g, f48_g, dual_g, ref_g;
    logic   div_q, dual_src;

    strap_sampler #(.WIN(STRAP_WIN)) u_strap (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .ss_pin (strap_ss_in),
        .sel_pin(strap_sel_in),
        .ts_pin (strap_ts_in),
        .done   (done),
        .straps (straps)
    );

    // Spread-spectrum flag: active once sampled, strap low means enabled.
    assign ss_en   = done & ~straps.ss_n;
    // Pins drive only after the window and only if not strapped tri-state.
    assign pins_on = done & straps.ts_n;

    clk_gate #(.SYNC(SYNC)) u_cpu_gate (
        .clk(cpu_clk), .rst_n(rst_n), .run(done & pd_n & cs_n), .gclk(cpu_g));
    clk_gate #(.SYNC(SYNC)) u_pci_gate (
        .clk(pci_clk), .rst_n(rst_n), .run(done & pd_n & ps_n), .gclk(pci_g));
    clk_gate #(.SYNC(SYNC)) u_pcif_gate (
        .clk(pci_clk), .rst_n(rst_n), .run(done & pd_n), .gclk(pcif_g));
    clk_gate #(.SYNC(SYNC)) u_f48_gate (
        .clk(f48_clk), .rst_n(rst_n), .run(done & pd_n), .gclk(f48_g));
    clk_gate #(.SYNC(SYNC)) u_ref_gate (
        .clk(ref_clk), .rst_n(rst_n), .run(done & pd_n), .gclk(ref_g));

    clk_div2 u_div (.clk(f48_clk), .rst_n(rst_n), .q(div_q));

    // Shared-pin source; the select is static once the gate can open.
    assign dual_src = straps.sel48_n ? div_q : f48_clk;

    clk_gate #(.SYNC(SYNC)) u_dual_gate (
        .clk(dual_src), .rst_n(rst_n), .run(done & pd_n), .gclk(dual_g));

    // Fan out the gated group clocks and enables to every pin.
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign cpu_out[c] = cpu_g;
        assign cpu_oe[c]  = pins_on;
    end
    for (genvar p = 0; p < NPCI; p++) begin : g_pci
        assign pci_out[p] = pci_g;
        assign pci_oe[p]  = pins_on;
    end
    for (genvar r = 0; r < NREF; r++) begin : g_ref
        assign ref_out[r] = ref_g;
        assign ref_oe[r]  = pins_on;
    end

    assign pci_f_out = pcif_g;
    assign pci_f_oe  = pins_on;
    assign fix48_out = f48_g;
    assign fix48_oe  = pins_on;
    assign dual_out  = dual_g;
    assign dual_oe   = pins_on;
endmodule

// Property checker bound to clk_out_ctrl. Stop windows are four source
// cycles long, which covers SYNC up to 3.
module clk_out_ctrl_chk #(
    parameter int NCPU = 2,
    parameter int NPCI = 5
) (
    input logic            ref_clk,
    input logic            cpu_clk,
    input logic            pci_clk,
    input logic            f48_clk,
    input logic            rst_n,
    input logic            pd_n,
    input logic            cs_n,
    input logic            ps_n,
    input logic [NCPU-1:0] cpu_out,
    input logic [NCPU-1:0] cpu_oe,
    input logic [NPCI-1:0] pci_out,
    input logic            fix48_out,
    input logic [1:0]      ref_oe,
    input logic            ss_en
);
    // R5
    cpu_stop_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && $past(!cs_n, 2) && $past(!cs_n, 3) && $past(!cs_n, 4))
        |-> (cpu_out == '0));

    // R6
    pci_stop_chk: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (!ps_n && $past(!ps_n) && $past(!ps_n, 2) && $past(!ps_n, 3) && $past(!ps_n, 4))
        |-> (pci_out == '0));

    // R7
    pd_stop_chk: assert property (@(negedge f48_clk) disable iff (!rst_n)
        (!pd_n && $past(!pd_n) && $past(!pd_n, 2) && $past(!pd_n, 3) && $past(!pd_n, 4))
        |-> !fix48_out);

    // R4
    oe_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(cpu_oe[0]) |-> cpu_oe[0]);

    // R2
    ss_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(ref_oe[0]) |-> $stable(ss_en));
endmodule

bind clk_out_ctrl clk_out_ctrl_chk #(.NCPU(NCPU), .NPCI(NPCI)) chk_i (
    .ref_clk  (ref_clk),
    .cpu_clk  (cpu_clk),
    .pci_clk  (pci_clk),
    .f48_clk  (f48_clk),
    .rst_n    (rst_n),
    .pd_n     (pd_n),
    .cs_n     (cs_n),
    .ps_n     (ps_n),
    .cpu_out  (cpu_out),
    .cpu_oe   (cpu_oe),
    .pci_out  (pci_out),
    .fix48_out(fix48_out),
    .ref_oe   (ref_oe),
    .ss_en    (ss_en)
);

// File: tb/clk_out_ctrl_tb_top.sv
`timescale 1ns/100ps
// Sweeps every strap combination and, when enabled, every control combination.
module clk_out_ctrl_tb_top;
    localparam int NCPU = 2;
    localparam int NPCI = 3;
    localparam int WIN  = 4;

    logic ref_clk = 0, cpu_clk = 0, pci_clk = 0, f48_clk = 0;
    logic rst_n = 0, pd_n = 1, cs_n = 1, ps_n = 1;
    logic s_ss = 1, s_sel = 1, s_ts = 1;
    logic [NCPU-1:0] cpu_out, cpu_oe;
    logic [NPCI-1:0] pci_out, pci_oe;
    logic pci_f_out, pci_f_oe, fix48_out, fix48_oe, dual_out, dual_oe, ss_en;
    logic [1:0] ref_out, ref_oe;

    always #4 cpu_clk = ~cpu_clk;   // 125 MHz
    always #7 pci_clk = ~pci_clk;
    always #5 f48_clk = ~f48_clk;
    always #9 ref_clk = ~ref_clk;

    clk_out_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .STRAP_WIN(WIN), .SYNC(2)) dut_i (
        .ref_clk(ref_clk), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .f48_clk(f48_clk),
        .rst_n(rst_n), .pd_n(pd_n), .cs_n(cs_n), .ps_n(ps_n),
        .strap_ss_in(s_ss), .strap_sel_in(s_sel), .strap_ts_in(s_ts),
        .cpu_out(cpu_out), .cpu_oe(cpu_oe), .pci_f_out(pci_f_out), .pci_f_oe(pci_f_oe),
        .pci_out(pci_out), .pci_oe(pci_oe), .fix48_out(fix48_out), .fix48_oe(fix48_oe),
        .dual_out(dual_out), .dual_oe(dual_oe), .ref_out(ref_out), .ref_oe(ref_oe),
        .ss_en(ss_en));

    int n_cpu_src = 0, n_pci_src = 0, n_f48_src = 0, n_ref_src = 0;
    int n_cpu0 = 0, n_cpu1 = 0, n_pci0 = 0, n_pcif = 0, n_f48 = 0, n_dual = 0, n_ref0 = 0, n_ref1 = 0;
    always @(posedge cpu_clk)    n_cpu_src++;
    always @(posedge pci_clk)    n_pci_src++;
    always @(posedge f48_clk)    n_f48_src++;
    always @(posedge ref_clk)    n_ref_src++;
    always @(posedge cpu_out[0]) n_cpu0++;
    always @(posedge cpu_out[NCPU-1]) n_cpu1++;
    always @(posedge pci_out[0]) n_pci0++;
    always @(posedge pci_f_out)  n_pcif++;
    always @(posedge fix48_out)  n_f48++;
    always @(posedge dual_out)   n_dual++;
    always @(posedge ref_out[0]) n_ref0++;
    always @(posedge ref_out[1]) n_ref1++;

    // R11: pulse-width monitors on the stoppable outputs.
    realtime t_cpu = 0, t_pci = 0;
    int runt_cpu = 0, runt_pci = 0;
    always @(posedge cpu_out[0]) t_cpu = $realtime;
    always @(negedge cpu_out[0]) if (rst_n && ($realtime - t_cpu) < 3.9) runt_cpu++;
    always @(posedge pci_out[0]) t_pci = $realtime;
    always @(negedge pci_out[0]) if (rst_n && ($realtime - t_pci) < 6.9) runt_pci++;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_wait(input int n);
        repeat (n) @(posedge ref_clk);
        #0.3;
    endtask

    function automatic int all_oe();
        return int'(&{cpu_oe, pci_oe, pci_f_oe, fix48_oe, dual_oe, ref_oe});
    endfunction
    function automatic int any_oe();
        return int'(|{cpu_oe, pci_oe, pci_f_oe, fix48_oe, dual_oe, ref_oe});
    endfunction

    initial begin : watchdog
        #1000000;
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        #0.3;
        for (int st = 0; st < 8; st++) begin
            s_ss = st[0]; s_sel = st[1]; s_ts = st[2];
            pd_n = 1; cs_n = 1; ps_n = 1;
            rst_n = 0;
            ref_wait(6);
            chk(any_oe() == 0 && ss_en == 0, "R1 reset state", any_oe(), 0);
            rst_n = 1;
            ref_wait(2);
            // R1: still inside the strap window
            chk(any_oe() == 0 && ss_en == 0, "R1 window", any_oe() + int'(ss_en), 0);
            ref_wait(WIN + 2);
            // R2: ss strap 0 means enabled
            chk(ss_en == !s_ss, "R2 ss_en", int'(ss_en), int'(!s_ss));
            if (!s_ts) begin
                chk(any_oe() == 0, "R4 tristate", any_oe(), 0);
                pd_n = 0; ref_wait(10); pd_n = 1; ref_wait(20);
                chk(any_oe() == 0, "R4 tristate held", any_oe(), 0);
            end else begin
                chk(all_oe() == 1, "R4 enabled", all_oe(), 1);
                for (int c = 0; c < 8; c++) begin
                    int b_cs, b_ps, b_f48, b_ref, b_c0, b_c1, b_p0, b_pf, b_48, b_du, b_r0, b_r1;
                    int d_cs, d_ps, d_f48, d_ref, exp_du;
                    bit xpd, xcs, xps;
                    xpd = c[0]; xcs = c[1]; xps = c[2];
                    pd_n = xpd; cs_n = xcs; ps_n = xps;
                    ref_wait(12);
                    b_cs = n_cpu_src; b_ps = n_pci_src; b_f48 = n_f48_src; b_ref = n_ref_src;
                    b_c0 = n_cpu0; b_c1 = n_cpu1; b_p0 = n_pci0; b_pf = n_pcif;
                    b_48 = n_f48; b_du = n_dual; b_r0 = n_ref0; b_r1 = n_ref1;
                    ref_wait(30);
                    d_cs = n_cpu_src - b_cs; d_ps = n_pci_src - b_ps;
                    d_f48 = n_f48_src - b_f48; d_ref = n_ref_src - b_ref;
                    // R5, R7
                    chk((n_cpu0 - b_c0) == ((xpd && xcs) ? d_cs : 0) &&
                        (n_cpu1 - b_c1) == (n_cpu0 - b_c0),
                        "R5 cpu_out", n_cpu0 - b_c0, (xpd && xcs) ? d_cs : 0);
                    // R6, R7
                    chk((n_pci0 - b_p0) == ((xpd && xps) ? d_ps : 0),
                        "R6 pci_out", n_pci0 - b_p0, (xpd && xps) ? d_ps : 0);
                    chk((n_pcif - b_pf) == (xpd ? d_ps : 0),
                        "R6 pci_f_out", n_pcif - b_pf, xpd ? d_ps : 0);
                    // R8, R7
                    chk((n_f48 - b_48) == (xpd ? d_f48 : 0),
                        "R8 fix48_out", n_f48 - b_48, xpd ? d_f48 : 0);
                    // R3: half rate when sel strap is 1
                    exp_du = !xpd ? 0 : (s_sel ? d_f48 / 2 : d_f48);
                    chk((n_dual - b_du) >= exp_du - 1 && (n_dual - b_du) <= exp_du + 1,
                        "R3 dual_out", n_dual - b_du, exp_du);
                    // R9, R7
                    chk((n_ref0 - b_r0) == (xpd ? d_ref : 0) && (n_ref1 - b_r1) == (n_ref0 - b_r0),
                        "R9 ref_out", n_ref0 - b_r0, xpd ? d_ref : 0);
                    // R7: held low level
                    if (!xpd)
                        chk({cpu_out, pci_out, pci_f_out, fix48_out, dual_out, ref_out} == '0,
                            "R7 held low", 1, 0);
                    // R10: straps retained across controls
                    chk(ss_en == !s_ss && all_oe() == 1, "R10 straps kept", int'(ss_en), int'(!s_ss));
                end
                // R11: toggle cs_n and ps_n at awkward phases
                pd_n = 1;
                for (int k = 0; k < 40; k++) begin
                    cs_n = ~cs_n; ps_n = k[1];
                    #(3.1 + (k % 7) * 1.7);
                end
                cs_n = 1; ps_n = 1;
                ref_wait(5);
            end
        end
        chk(runt_cpu == 0, "R11 cpu pulse width", runt_cpu, 0);
        chk(runt_pci == 0, "R11 pci pulse width", runt_pci, 0);
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule